// File: doc/BRIEF.md
# Single-Channel Transfer Engine

This block moves a programmed number of data items from a source address to a destination address while the processor does other work. Software sets up a peripheral-side address, a memory-side address, an item count and a control word through a small register-write port, then sets the enable bit. Each item is fetched with one read beat on the bus master port and written back with one write beat, and then the remaining count drops by one.

In peripheral-driven operation one item moves per request from the attached peripheral. A one-cycle acknowledge answers each request once its item has been written. In memory-to-memory operation the engine runs on its own, with no requests, until the count runs out. Circular operation restores the count and both working addresses from their programmed values after the last item, so a peripheral stream can run without end. Circular operation is ignored while memory-to-memory is selected.

The bus master port uses a valid/ready handshake. The engine raises `bus_valid` and then holds `bus_write`, `bus_addr`, `bus_size` and `bus_wdata` unchanged until it samples `bus_ready` high on a rising clock edge. That edge completes the beat, and for a read `bus_rdata` is taken in the same cycle. The slave may hold `bus_ready` low for as long as it needs, and `bus_ready` may depend on `bus_valid`. The engine never withdraws a beat it has offered.

Top module: `dma_xfer_engine`

## Requirements
- R1: While reset is asserted and after its release, with no configuration written, `bus_valid` and `periph_ack` stay low even if `periph_req` is high.
- R2: Each item is one read beat at the source address followed by one write beat to the destination address, carrying the data read. While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_write` and `bus_addr` hold their values into the next cycle.
- R3: Control bit 1 selects direction. With 0 the peripheral address is the source and the memory address is the destination. With 1 the memory address is the source and the peripheral address is the destination.
- R4: Control bit 3 (peripheral side) and control bit 4 (memory side) each make that working address advance after every item. The step is set by the size field in control bits 6:5, which also drives `bus_size`: code 0 steps 1 byte, code 1 steps 2 bytes, and codes 2 and 3 step 4 bytes. When its bit is clear, an address does not move.
- R5: In normal mode (control bit 2 clear) the channel moves exactly the programmed count of items and then ignores further requests.
- R6: In circular mode (control bit 2 set, bit 7 clear), once the last item is done the remaining count and both working addresses return to their programmed values, and requests keep being served.
- R7: With control bit 7 set (memory-to-memory), items move without any `periph_req`, `periph_ack` never rises, and the engine stops once the count reaches zero.
- R8: With control bits 7 and 2 both set, the engine behaves as in normal mode and stops after the programmed count.
- R9: In peripheral-driven mode each request moves one item. `periph_ack` is high for exactly the one cycle that follows the completed write beat.
- R10: Register selects 0 (peripheral address), 1 (memory address) and 2 (count, low 16 bits) accept writes only while control bit 0 (enable) is clear. Select 3 (control) always accepts writes.
- R11: No new item starts while enable is clear or while the remaining count is zero. A programmed count of zero moves nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 peripheral address, 1 memory address, 2 count, 3 control |
| cfg_wdata | input | AW | Register write data |
| periph_req | input | 1 | Item request from the peripheral, held until acknowledged |
| periph_ack | output | 1 | One-cycle acknowledge after the item is written |
| bus_valid | output | 1 | Bus beat offered |
| bus_ready | input | 1 | Bus slave accepts the beat |
| bus_write | output | 1 | 1 for a write beat, 0 for a read beat |
| bus_addr | output | AW | Byte address of the beat |
| bus_size | output | 2 | Item width code (0 byte, 1 half-word, 2 or 3 word) |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, sampled when a read beat completes |

## Verification
The hardest case to reach is the circular reload landing in the same beat as back-pressure and a pending request. The count, both pointers and the handshake all change on one edge, and that is only visible if the bus stalls around the last item of a pass. The vector table therefore runs circular streams with more requests than the count, so that the wrap happens twice. It also runs several vectors with a slave that is ready only one cycle in three, and it predicts every beat's address and data from the wrapped item index. A second hard case is proving that writes to locked registers were ignored. A directed test tries to rewrite the address and a larger count while the channel is enabled, then shows that the old address is used and that the channel still stops after the original count.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [1:0] {
    SEL_PADDR = 2'd0,
    SEL_MADDR = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_CTRL  = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_ACK
  } seq_state_e;

  // control word, bit 0 at the bottom
  typedef struct packed {
    logic       m2m;   // 7
    logic [1:0] size;  // 6:5
    logic       minc;  // 4
    logic       pinc;  // 3
    logic       circ;  // 2
    logic       dir;   // 1
    logic       en;    // 0
  } chan_ctrl_t;

  localparam int CTRL_W     = $bits(chan_ctrl_t);
  localparam int SIDE_PERIPH = 0;
  localparam int SIDE_MEM    = 1;
  localparam int NUM_SIDES   = 2;

  function automatic logic [2:0] item_step(input logic [1:0] size);
    case (size)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_xfer_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output chan_ctrl_t    ctrl,
  output logic          circ_eff,
  output logic [AW-1:0] base_paddr,
  output logic [AW-1:0] base_maddr,
  output logic [CW-1:0] base_cnt,
  output logic          ld_paddr,
  output logic          ld_maddr,
  output logic          ld_cnt
);

  cfg_sel_e sel;
  logic     locked_wr;

  assign sel       = cfg_sel_e'(cfg_sel);
  assign locked_wr = cfg_we && !ctrl.en;
  assign ld_paddr  = locked_wr && (sel == SEL_PADDR);
  assign ld_maddr  = locked_wr && (sel == SEL_MADDR);
  assign ld_cnt    = locked_wr && (sel == SEL_COUNT);

  // circular is overridden by memory-to-memory
  assign circ_eff = ctrl.circ && !ctrl.m2m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl       <= '0;
      base_paddr <= '0;
      base_maddr <= '0;
      base_cnt   <= '0;
    end else begin
      if (ld_paddr) base_paddr <= cfg_wdata;
      if (ld_maddr) base_maddr <= cfg_wdata;
      if (ld_cnt)   base_cnt   <= cfg_wdata[CW-1:0];
      if (cfg_we && sel == SEL_CTRL) ctrl <= chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    end
  end

  assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && cfg_we) |=> ($stable(base_paddr) && $stable(base_maddr) && $stable(base_cnt)));

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_xfer_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ld_val,
  input  logic          ld_paddr,
  input  logic          ld_maddr,
  input  logic          ld_cnt,
  input  logic [AW-1:0] base_paddr,
  input  logic [AW-1:0] base_maddr,
  input  logic [CW-1:0] base_cnt,
  input  logic          pinc,
  input  logic          minc,
  input  logic [1:0]    size,
  input  logic          circ_eff,
  input  logic          m2m,
  input  logic          item_done,
  output logic [AW-1:0] work_paddr,
  output logic [AW-1:0] work_maddr,
  output logic          cnt_zero
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [NUM_SIDES-1:0][AW-1:0] base_a;
  logic [NUM_SIDES-1:0][AW-1:0] work_a;
  logic [NUM_SIDES-1:0]         ld_a;
  logic [NUM_SIDES-1:0]         inc_a;
  logic [CW-1:0]                rem_cnt;
  logic [AW-1:0]                step_w;
  logic                         last_item;
  logic                         wrap;

  assign base_a[SIDE_PERIPH] = base_paddr;
  assign base_a[SIDE_MEM]    = base_maddr;
  assign ld_a[SIDE_PERIPH]   = ld_paddr;
  assign ld_a[SIDE_MEM]      = ld_maddr;
  assign inc_a[SIDE_PERIPH]  = pinc;
  assign inc_a[SIDE_MEM]     = minc;

  assign step_w    = AW'(item_step(size));
  assign last_item = item_done && (rem_cnt == CNT_ONE);
  assign wrap      = last_item && circ_eff;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    logic [AW-1:0] ptr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ptr_q <= '0;
      else if (ld_a[s])              ptr_q <= ld_val;
      else if (wrap)                 ptr_q <= base_a[s];
      else if (item_done && inc_a[s]) ptr_q <= ptr_q + step_w;
    end
    assign work_a[s] = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rem_cnt <= '0;
    else if (ld_cnt)     rem_cnt <= ld_val[CW-1:0];
    else if (item_done)  rem_cnt <= wrap ? base_cnt : rem_cnt - CNT_ONE;
  end

  assign work_paddr = work_a[SIDE_PERIPH];
  assign work_maddr = work_a[SIDE_MEM];
  assign cnt_zero   = (rem_cnt == '0);

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    item_done |-> !cnt_zero);

  assert_stop_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_item && !circ_eff) |=> cnt_zero);

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_item && circ_eff) |=> (rem_cnt == $past(base_cnt) && work_paddr == $past(base_paddr)
                                 && work_maddr == $past(base_maddr)));

  assert_m2m_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_item && m2m) |=> cnt_zero);

  assert_pstep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && pinc && rem_cnt != CNT_ONE && !ld_paddr) |=> work_paddr == $past(work_paddr + step_w));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_xfer_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          m2m,
  input  logic          dir,
  input  logic [1:0]    size,
  input  logic          cnt_zero,
  input  logic          periph_req,
  input  logic [AW-1:0] paddr,
  input  logic [AW-1:0] maddr,
  output logic          periph_ack,
  output logic          item_done,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata
);

  seq_state_e    state_q, state_d;
  logic [DW-1:0] hold_q;
  logic          start;

  assign start = en && !cnt_zero && (m2m || periph_req);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_READ;
      ST_READ:  if (bus_ready) state_d = ST_WRITE;
      ST_WRITE: if (bus_ready) state_d = m2m ? ST_IDLE : ST_ACK;
      ST_ACK:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_READ && bus_ready) hold_q <= bus_rdata;
    end
  end

  assign bus_valid  = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign bus_write  = (state_q == ST_WRITE);
  // read beats use the source side, write beats the destination side
  assign bus_addr   = (bus_write ^ dir) ? maddr : paddr;
  assign bus_size   = size;
  assign bus_wdata  = hold_q;
  assign item_done  = (state_q == ST_WRITE) && bus_ready;
  assign periph_ack = (state_q == ST_ACK);

  assert_hold_under_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_write) && $stable(bus_addr)));

  assert_read_before_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_write) |-> $past(bus_valid && bus_ready && !bus_write));

  assert_ack_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ack |-> ($past(item_done) && !$past(m2m)));

  assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ack |=> !periph_ack);

  assert_start_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !$past(bus_valid)) |-> $past(en && !cnt_zero));

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          periph_req,
  output logic          periph_ack,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);

  chan_ctrl_t    ctrl;
  logic          circ_eff;
  logic [AW-1:0] base_paddr, base_maddr;
  logic [CW-1:0] base_cnt;
  logic          ld_paddr, ld_maddr, ld_cnt;
  logic [AW-1:0] work_paddr, work_maddr;
  logic          cnt_zero;
  logic          item_done;

  dma_cfg_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .ctrl       (ctrl),
    .circ_eff   (circ_eff),
    .base_paddr (base_paddr),
    .base_maddr (base_maddr),
    .base_cnt   (base_cnt),
    .ld_paddr   (ld_paddr),
    .ld_maddr   (ld_maddr),
    .ld_cnt     (ld_cnt)
  );

  dma_addr_gen #(.AW(AW), .CW(CW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_val     (cfg_wdata),
    .ld_paddr   (ld_paddr),
    .ld_maddr   (ld_maddr),
    .ld_cnt     (ld_cnt),
    .base_paddr (base_paddr),
    .base_maddr (base_maddr),
    .base_cnt   (base_cnt),
    .pinc       (ctrl.pinc),
    .minc       (ctrl.minc),
    .size       (ctrl.size),
    .circ_eff   (circ_eff),
    .m2m        (ctrl.m2m),
    .item_done  (item_done),
    .work_paddr (work_paddr),
    .work_maddr (work_maddr),
    .cnt_zero   (cnt_zero)
  );

  dma_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (ctrl.en),
    .m2m        (ctrl.m2m),
    .dir        (ctrl.dir),
    .size       (ctrl.size),
    .cnt_zero   (cnt_zero),
    .periph_req (periph_req),
    .paddr      (work_paddr),
    .maddr      (work_maddr),
    .periph_ack (periph_ack),
    .item_done  (item_done),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .bus_ready  (bus_ready),
    .bus_rdata  (bus_rdata)
  );

endmodule

// File: tb/dma_xfer_engine_tb.sv
module dma_xfer_engine_tb;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LOGN = 512;

  typedef struct packed {
    logic        dir;
    logic        circ;
    logic        pinc;
    logic        minc;
    logic [1:0]  size;
    logic        m2m;
    logic        bp;
    logic [15:0] cnt;
    logic [7:0]  nreq;
    logic [31:0] pa;
    logic [31:0] ma;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 16'd4, 8'd4, 32'h4000_1000, 32'h2000_0000},
    '{1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 16'd3, 8'd3, 32'h4000_2004, 32'h2000_0100},
    '{1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 16'd3, 8'd7, 32'h4000_3000, 32'h2000_0200},
    '{1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 16'd5, 8'd0, 32'h2000_4000, 32'h2000_0400},
    '{1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 16'd3, 8'd0, 32'h2000_5000, 32'h2000_0600},
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 16'd2, 8'd5, 32'h4000_6000, 32'h2000_0700}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          periph_req = 1'b0;
  logic          periph_ack;
  logic          bus_valid;
  logic          bus_ready = 1'b0;
  logic          bus_write;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;

  int checks = 0;
  int failures = 0;
  logic cur_m2m = 1'b0;
  logic bp_mode = 1'b0;

  // monitor state (written only by the monitor)
  logic          lg_wr   [LOGN];
  logic [31:0]   lg_addr [LOGN];
  logic [31:0]   lg_data [LOGN];
  logic [1:0]    lg_size [LOGN];
  int            lg_n = 0;
  int            ack_err = 0;
  int            bp_err = 0;
  int            cyc = 0;
  logic          ack_due = 1'b0;
  logic          stalled = 1'b0;
  logic          st_wr = 1'b0;
  logic [31:0]   st_addr = '0;

  always #4 clk = ~clk;

  dma_xfer_engine #(.AW(AW), .DW(DW), .CW(16)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .periph_req (periph_req),
    .periph_ack (periph_ack),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata)
  );

  function automatic logic [31:0] rd_model(input logic [31:0] a);
    return {~a[15:0], a[15:0] ^ 16'h5A5A};
  endfunction

  function automatic int step_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] mk_ctrl(input logic en, input vec_t v);
    return {24'd0, v.m2m, v.size, v.minc, v.pinc, v.circ, v.dir, en};
  endfunction

  // bus slave model and protocol monitor
  always @(negedge clk) begin
    logic rdy;
    if (!rst_n) begin
      bus_ready = 1'b0;
      ack_due   = 1'b0;
      stalled   = 1'b0;
    end else begin
      if (ack_due != periph_ack) ack_err++;
      if (stalled && (!bus_valid || bus_addr != st_addr || bus_write != st_wr)) bp_err++;
      cyc++;
      rdy = !bp_mode || (cyc % 3 == 0);
      bus_ready = rdy;
      bus_rdata = rd_model(bus_addr);
      ack_due   = bus_valid && rdy && bus_write && !cur_m2m;
      stalled   = bus_valid && !rdy;
      st_addr   = bus_addr;
      st_wr     = bus_write;
      if (bus_valid && rdy && lg_n < LOGN) begin
        lg_wr[lg_n]   = bus_write;
        lg_addr[lg_n] = bus_addr;
        lg_data[lg_n] = bus_wdata;
        lg_size[lg_n] = bus_size;
        lg_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_reqs(input int n, output int got);
    got = 0;
    for (int i = 0; i < n; i++) begin
      int t = 0;
      @(negedge clk);
      periph_req = 1'b1;
      while (!periph_ack && t < 200) begin
        @(negedge clk);
        t++;
      end
      if (periph_ack) got++;
      periph_req = 1'b0;
      if (t >= 200) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 1);
    $finish;
  end

  initial begin
    int got;
    int base_n, base_ack, base_bp;
    // R1: reset state, and a request with nothing configured
    periph_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bus_valid && !periph_ack, "R1", "outputs in reset", {bus_valid, periph_ack}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!bus_valid && !periph_ack && lg_n == 0, "R1", "idle after reset", lg_n, 0);
    periph_req = 1'b0;

    // table-driven streams
    for (int vi = 0; vi < NV; vi++) begin
      vec_t v;
      int items, stp;
      logic ce;
      v = VECS[vi];
      cur_m2m = v.m2m;
      bp_mode = v.bp;
      ce = v.circ && !v.m2m;
      stp = step_of(v.size);
      items = v.m2m ? int'(v.cnt) : (ce ? int'(v.nreq) :
              (int'(v.nreq) < int'(v.cnt) ? int'(v.nreq) : int'(v.cnt)));
      cfg_write(2'd3, mk_ctrl(1'b0, v));
      cfg_write(2'd0, v.pa);
      cfg_write(2'd1, v.ma);
      cfg_write(2'd2, {16'd0, v.cnt});
      base_n = lg_n; base_ack = ack_err; base_bp = bp_err;
      cfg_write(2'd3, mk_ctrl(1'b1, v));
      if (!v.m2m) begin
        send_reqs(int'(v.nreq), got);
        chk(got == int'(v.nreq), "R9", "acks per request", got, v.nreq);
      end
      repeat (120) @(negedge clk);
      // R5 R7 R8: exact number of beats
      chk(lg_n - base_n == 2 * items, v.m2m ? "R7" : "R5", "beat count", lg_n - base_n, 2 * items);
      for (int i = 0; i < items && (base_n + 2 * i + 1) < lg_n; i++) begin
        int k;
        logic [31:0] pa_i, ma_i, src, dst;
        int r;
        k = ce ? (i % int'(v.cnt)) : i;
        pa_i = v.pa + (v.pinc ? 32'(k * stp) : 32'd0);
        ma_i = v.ma + (v.minc ? 32'(k * stp) : 32'd0);
        src = v.dir ? ma_i : pa_i;
        dst = v.dir ? pa_i : ma_i;
        r = base_n + 2 * i;
        // R2 R3 R4 R6: read at source, write same data at destination
        chk(!lg_wr[r] && lg_addr[r] == src && lg_size[r] == v.size, ce ? "R6" : "R3",
            "read beat address", lg_addr[r], src);
        chk(lg_wr[r+1] && lg_addr[r+1] == dst, "R4", "write beat address", lg_addr[r+1], dst);
        chk(lg_data[r+1] == rd_model(src), "R2", "write beat data", lg_data[r+1], rd_model(src));
      end
      chk(ack_err == base_ack, "R9", "ack timing errors", ack_err - base_ack, 0);
      chk(bp_err == base_bp, "R2", "stall hold errors", bp_err - base_bp, 0);
      cfg_write(2'd3, mk_ctrl(1'b0, v));
    end

    // R10: locked registers while enabled; R5: stop after count
    begin
      vec_t v;
      v = VECS[0];
      cur_m2m = 1'b0; bp_mode = 1'b0;
      cfg_write(2'd0, 32'h4000_3000);
      cfg_write(2'd1, 32'h2000_0300);
      cfg_write(2'd2, 32'd2);
      cfg_write(2'd3, mk_ctrl(1'b1, v));
      cfg_write(2'd0, 32'h5555_0000);
      cfg_write(2'd2, 32'd9);
      base_n = lg_n;
      send_reqs(1, got);
      repeat (5) @(negedge clk);
      chk(lg_n > base_n && lg_addr[base_n] == 32'h4000_3000, "R10", "address kept while enabled",
          lg_addr[base_n], 32'h4000_3000);
      send_reqs(1, got);
      send_reqs(1, got);
      chk(got == 0, "R5", "request after count served", got, 0);
      chk(lg_n - base_n == 4, "R10", "count kept while enabled", lg_n - base_n, 4);
      cfg_write(2'd3, mk_ctrl(1'b0, v));
    end

    // R11: disabled channel and zero count
    begin
      vec_t v;
      v = VECS[0];
      cfg_write(2'd2, 32'd3);
      cfg_write(2'd3, mk_ctrl(1'b1, v));
      cfg_write(2'd3, mk_ctrl(1'b0, v));
      base_n = lg_n;
      send_reqs(1, got);
      chk(got == 0 && lg_n == base_n, "R11", "disabled channel moved data", lg_n - base_n, 0);
      v = VECS[3];
      cur_m2m = 1'b1;
      cfg_write(2'd2, 32'd0);
      cfg_write(2'd3, mk_ctrl(1'b1, v));
      repeat (30) @(negedge clk);
      chk(lg_n == base_n, "R11", "zero count moved data", lg_n - base_n, 0);
      chk(!periph_ack, "R7", "ack in memory-to-memory", periph_ack, 0);
      cfg_write(2'd3, mk_ctrl(1'b0, v));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule